// File: doc/BRIEF.md
# Transmit command decoder with sender lock

This block sits between an on-chip bus receive port and the transmit side of a UDP engine. Each bus message begins with an address word that names the sender, followed by 32-bit command words. The block sorts the commands by the 4-bit type field in the first command word. A four-word configuration stores the timeout, the destination IP, the two UDP ports and the acknowledgement address, and binds them to its sender. A start command opens a packet. A release command frees the binding.

A start from the binding sender produces a one-cycle `pkt_start` pulse together with the byte length. The length and the stored parameters stay steady on the outputs until the packet has drained. The payload words that follow are split into 16-bit halfwords for the UDP side. Starts and releases from any other sender are dropped and raise `illegal` for one cycle.

The command input and the acknowledgement output are valid/ready streams. A word moves only on a cycle where both valid and ready are high. While `ack_valid` is high and `ack_ready` is low, the acknowledgement word holds. The halfword output uses a single read strobe, `hw_rd`, which takes effect only on its rising edge.

Top module: `txlock_decoder`

## Requirements
- R1: After reset the block is unbound, `in_ready` is 1, and `ack_valid`, `pkt_busy` and `hw_valid` are 0.
- R2: The command type sits in bits 31:28 of the first command word. Type 0 is configuration, and it is followed by three more words: the destination IP, a port word (destination port in bits 31:16, source port in bits 15:0), and the acknowledgement address. Bits 27:0 of the first word are the timeout. When the block is unbound, or the configuration comes from the binding sender, all four values appear on the outputs and the block binds to that sender. It then raises `ack_valid` with `ack_data` = 0x58000000, and `ack_dest` carries the new acknowledgement address.
- R3: A command word is consumed only when `in_valid` and `in_ready` are both 1. While `ack_valid` is 1 and `ack_ready` is 0, `ack_valid` and `ack_data` hold. The handshake cycle clears `ack_valid`. The final configuration word is not accepted while an earlier acknowledgement is still pending.
- R4: A type 1 word from the binding sender with a nonzero byte length in bits 27:17 gives a one-cycle `pkt_start` and sets `pkt_len` to that length. A zero length gives neither a pulse nor `illegal`.
- R5: A type 1 or type 2 word from a sender that is not bound, including any sender while the block is unbound, gives a one-cycle `illegal`, no `pkt_start`, and leaves the binding unchanged. The words that follow it, up to the next address word, are discarded.
- R6: A type 2 word from the binding sender unbinds the block. A later start from that sender is then illegal, and a configuration from another sender is accepted.
- R7: A configuration from a non-binding sender while bound gives `illegal`, no acknowledgement, and leaves every parameter output unchanged.
- R8: The number of halfwords delivered is the byte length divided by 2, rounded up. Each payload word gives its bits 15:0 first, then its bits 31:16. A last word that holds only one halfword delivers only its low half.
- R9: When the byte length is odd, bits 15:8 of the final halfword read as zero.
- R10: A halfword is consumed only on a cycle where `hw_rd` is 1 and was 0 the cycle before. Holding `hw_rd` high consumes exactly one halfword.
- R11: `pkt_busy` is 1 from the start pulse until the last halfword has been consumed. During that time `pkt_len`, `dst_ip`, `dst_port` and `src_port` are stable. `in_ready` is 0 while a payload halfword is waiting.
- R12: Type 3 and the other unused types are consumed with no acknowledgement, no `illegal` and no change to the binding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Command word taken this cycle |
| in_is_addr | input | 1 | Word is a sender address |
| in_data | input | 32 | Command, address or payload word |
| ack_valid | output | 1 | Acknowledgement pending |
| ack_ready | input | 1 | Acknowledgement taken |
| ack_data | output | 32 | Acknowledgement word |
| ack_dest | output | ADDR_W | Bus address the acknowledgement goes to |
| pkt_start | output | 1 | One-cycle packet-start pulse |
| pkt_len | output | LEN_W | Packet byte length |
| pkt_busy | output | 1 | Packet in progress |
| dst_ip | output | 32 | Destination IP address |
| dst_port | output | 16 | Destination UDP port |
| src_port | output | 16 | Source UDP port |
| timeout | output | 28 | Stored timeout value |
| hw_valid | output | 1 | Payload halfword available |
| hw_data | output | 16 | Payload halfword |
| hw_rd | input | 1 | Edge-sensitive halfword read strobe |
| illegal | output | 1 | One-cycle flag for a rejected command |

## Verification
The bench builds the block with its defaults: 32-bit sender addresses and an 11-bit length field. Short lengths (1, 6, 7 and 12 bytes) then cover a single padded halfword, an odd halfword count that leaves the last word half used, an odd byte count, and multi-word packets. Two distinct 32-bit sender addresses are enough to exercise binding, rejection and release. A hold of three cycles on the read strobe exposes any level-sensitive consumption.

// File: rtl/txlock_pkg.sv
package txlock_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_CFG, ST_PAY} txl_state_e;

  localparam int          CMD_W     = 32;
  localparam int          TIMEOUT_W = 28;
  localparam int          PORT_W    = 16;
  localparam int          HALF_W    = 16;
  localparam int          TYPE_MSB  = 31;
  localparam int          TYPE_LSB  = 28;

  localparam logic [3:0]  CMD_TX_CFG   = 4'd0;
  localparam logic [3:0]  CMD_TX_START = 4'd1;
  localparam logic [3:0]  CMD_RELEASE  = 4'd2;

  localparam logic [7:0]  ACK_CFG_CODE = 8'h58;
endpackage

// File: rtl/txlock_param_bank.sv
module txlock_param_bank
  import txlock_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 st_we,
  input  logic [1:0]           st_idx,
  input  logic [CMD_W-1:0]     st_word,
  input  logic                 commit,
  input  logic [ADDR_W-1:0]    commit_owner,
  input  logic                 release_i,
  output logic                 locked,
  output logic [ADDR_W-1:0]    owner,
  output logic [TIMEOUT_W-1:0] timeout,
  output logic [CMD_W-1:0]     dst_ip,
  output logic [PORT_W-1:0]    dst_port,
  output logic [PORT_W-1:0]    src_port,
  output logic [ADDR_W-1:0]    ack_addr
);
  logic [TIMEOUT_W-1:0] stg_timeout;
  logic [CMD_W-1:0]     stg_ip;
  logic [CMD_W-1:0]     stg_ports;

  // staging registers collect the first three words of a configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_timeout <= '0;
      stg_ip      <= '0;
      stg_ports   <= '0;
    end else if (st_we) begin
      case (st_idx)
        2'd0:    stg_timeout <= st_word[TIMEOUT_W-1:0];
        2'd1:    stg_ip      <= st_word;
        2'd2:    stg_ports   <= st_word;
        default: ;
      endcase
    end
  end

  // live registers change only on a complete configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      owner    <= '0;
      timeout  <= '0;
      dst_ip   <= '0;
      dst_port <= '0;
      src_port <= '0;
      ack_addr <= '0;
    end else if (commit) begin
      locked   <= 1'b1;
      owner    <= commit_owner;
      timeout  <= stg_timeout;
      dst_ip   <= stg_ip;
      dst_port <= stg_ports[CMD_W-1:PORT_W];
      src_port <= stg_ports[PORT_W-1:0];
      ack_addr <= st_word[ADDR_W-1:0];
    end else if (release_i) begin
      locked <= 1'b0;
    end
  end

  // R6
  unlock_only_by_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !release_i) |=> locked);
endmodule

// File: rtl/txlock_half_unpacker.sv
module txlock_half_unpacker #(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [2*HALF_W-1:0]   word,
  input  logic                  two_halves,
  input  logic                  pad_last,
  input  logic                  hw_rd,
  output logic                  hw_valid,
  output logic [HALF_W-1:0]     hw_data,
  output logic                  empty
);
  localparam int BYTE_W = HALF_W / 2;

  logic [2*HALF_W-1:0] buf_q;
  logic [1:0]          left_q;
  logic                sel_q;
  logic                pad_q;
  logic                rd_q;
  logic                take;

  assign hw_valid = (left_q != 2'd0);
  assign empty    = (left_q == 2'd0);
  assign take     = hw_rd && !rd_q && hw_valid;

  always_comb begin
    hw_data = sel_q ? buf_q[2*HALF_W-1:HALF_W] : buf_q[HALF_W-1:0];
    if (pad_q && (left_q == 2'd1))
      hw_data[HALF_W-1:BYTE_W] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      left_q <= 2'd0;
      sel_q  <= 1'b0;
      pad_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      rd_q <= hw_rd;
      if (load) begin
        buf_q  <= word;
        left_q <= two_halves ? 2'd2 : 2'd1;
        sel_q  <= 1'b0;
        pad_q  <= pad_last;
      end else if (take) begin
        left_q <= left_q - 2'd1;
        sel_q  <= 1'b1;
      end
    end
  end

  // R10
  no_back_to_back_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  // R10
  held_strobe_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && hw_rd && $past(hw_rd)) |=> $stable(hw_data));
endmodule

// File: rtl/txlock_cmd_fsm.sv
module txlock_cmd_fsm
  import txlock_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_is_addr,
  input  logic [CMD_W-1:0]    in_data,
  output logic                ack_valid,
  input  logic                ack_ready,
  output logic [CMD_W-1:0]    ack_data,
  input  logic                locked,
  input  logic [ADDR_W-1:0]   owner,
  output logic                st_we,
  output logic [1:0]          st_idx,
  output logic [CMD_W-1:0]    st_word,
  output logic                commit,
  output logic [ADDR_W-1:0]   sender,
  output logic                release_o,
  output logic                pkt_start,
  output logic [LEN_W-1:0]    pkt_len,
  output logic                pkt_busy,
  output logic                illegal,
  input  logic                unp_empty,
  output logic                unp_load,
  output logic [CMD_W-1:0]    unp_word,
  output logic                unp_two,
  output logic                unp_pad
);
  localparam int WL_W    = LEN_W - 1;
  localparam int LEN_MSB = TYPE_LSB - 1;

  txl_state_e        state;
  logic [1:0]        cfg_idx;
  logic [WL_W-1:0]   words_left;
  logic              hw_odd;
  logic              len_odd;

  logic              fire;
  logic [3:0]        cmd_type;
  logic [LEN_W-1:0]  len_f;
  logic              owner_match;
  logic              cfg_ok;
  logic [LEN_W:0]    hw_tmp;
  logic [LEN_W:0]    wl_tmp;
  logic              last_word;
  logic              is_cmd;

  assign fire        = in_valid && in_ready;
  assign cmd_type    = in_data[TYPE_MSB:TYPE_LSB];
  assign len_f       = in_data[LEN_MSB -: LEN_W];
  assign owner_match = locked && (sender == owner);
  assign cfg_ok      = !locked || owner_match;
  assign hw_tmp      = {1'b0, len_f} + (LEN_W+1)'(1);
  assign wl_tmp      = {1'b0, len_f} + (LEN_W+1)'(3);
  assign last_word   = (words_left == WL_W'(1));
  assign is_cmd      = fire && !in_is_addr;

  always_comb begin
    case (state)
      ST_IDLE, ST_HDR: in_ready = 1'b1;
      ST_CFG:          in_ready = (cfg_idx == 2'd3) ? !ack_valid : 1'b1;
      ST_PAY:          in_ready = unp_empty && (words_left != '0);
      default:         in_ready = 1'b0;
    endcase
  end

  assign st_we     = (state == ST_HDR && is_cmd && cmd_type == CMD_TX_CFG && cfg_ok)
                   || (state == ST_CFG && is_cmd);
  assign st_idx    = (state == ST_HDR) ? 2'd0 : cfg_idx;
  assign st_word   = in_data;
  assign commit    = (state == ST_CFG) && is_cmd && (cfg_idx == 2'd3);
  assign release_o = (state == ST_HDR) && is_cmd && (cmd_type == CMD_RELEASE) && owner_match;
  assign unp_load  = (state == ST_PAY) && fire;
  assign unp_word  = in_data;
  assign unp_two   = !(last_word && hw_odd);
  assign unp_pad   = last_word && len_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sender     <= '0;
      cfg_idx    <= 2'd0;
      words_left <= '0;
      hw_odd     <= 1'b0;
      len_odd    <= 1'b0;
      ack_valid  <= 1'b0;
      ack_data   <= '0;
      pkt_start  <= 1'b0;
      pkt_len    <= '0;
      pkt_busy   <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      pkt_start <= 1'b0;
      illegal   <= 1'b0;
      if (ack_valid && ack_ready)
        ack_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fire && in_is_addr) begin
            sender <= in_data[ADDR_W-1:0];
            state  <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (fire) begin
            if (in_is_addr) begin
              sender <= in_data[ADDR_W-1:0];
            end else begin
              state <= ST_IDLE;
              case (cmd_type)
                CMD_TX_CFG: begin
                  if (cfg_ok) begin
                    state   <= ST_CFG;
                    cfg_idx <= 2'd1;
                  end else begin
                    illegal <= 1'b1;
                  end
                end
                CMD_TX_START: begin
                  if (!owner_match) begin
                    illegal <= 1'b1;
                  end else if (len_f != '0) begin
                    pkt_start  <= 1'b1;
                    pkt_len    <= len_f;
                    pkt_busy   <= 1'b1;
                    words_left <= wl_tmp[LEN_W:2];
                    hw_odd     <= hw_tmp[1];
                    len_odd    <= len_f[0];
                    state      <= ST_PAY;
                  end
                end
                CMD_RELEASE: begin
                  if (!owner_match)
                    illegal <= 1'b1;
                end
                default: ;
              endcase
            end
          end
        end
        ST_CFG: begin
          if (fire) begin
            if (in_is_addr) begin
              sender <= in_data[ADDR_W-1:0];
              state  <= ST_HDR;
            end else if (cfg_idx == 2'd3) begin
              ack_valid <= 1'b1;
              ack_data  <= {ACK_CFG_CODE, {(CMD_W-8){1'b0}}};
              state     <= ST_IDLE;
            end else begin
              cfg_idx <= cfg_idx + 2'd1;
            end
          end
        end
        ST_PAY: begin
          if (unp_load) begin
            words_left <= words_left - WL_W'(1);
          end else if (words_left == '0 && unp_empty) begin
            pkt_busy <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_data)));
  // R5
  start_not_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_start && illegal));
endmodule

// File: rtl/txlock_decoder.sv
module txlock_decoder
  import txlock_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_is_addr,
  input  logic [31:0]          in_data,
  output logic                 ack_valid,
  input  logic                 ack_ready,
  output logic [31:0]          ack_data,
  output logic [ADDR_W-1:0]    ack_dest,
  output logic                 pkt_start,
  output logic [LEN_W-1:0]     pkt_len,
  output logic                 pkt_busy,
  output logic [31:0]          dst_ip,
  output logic [15:0]          dst_port,
  output logic [15:0]          src_port,
  output logic [27:0]          timeout,
  output logic                 hw_valid,
  output logic [15:0]          hw_data,
  input  logic                 hw_rd,
  output logic                 illegal
);
  logic              locked;
  logic [ADDR_W-1:0] owner;
  logic              st_we;
  logic [1:0]        st_idx;
  logic [CMD_W-1:0]  st_word;
  logic              commit;
  logic [ADDR_W-1:0] sender;
  logic              release_s;
  logic              unp_empty;
  logic              unp_load;
  logic [CMD_W-1:0]  unp_word;
  logic              unp_two;
  logic              unp_pad;

  txlock_cmd_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_addr(in_is_addr), .in_data(in_data),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_data(ack_data),
    .locked(locked), .owner(owner),
    .st_we(st_we), .st_idx(st_idx), .st_word(st_word), .commit(commit),
    .sender(sender), .release_o(release_s),
    .pkt_start(pkt_start), .pkt_len(pkt_len), .pkt_busy(pkt_busy), .illegal(illegal),
    .unp_empty(unp_empty), .unp_load(unp_load), .unp_word(unp_word),
    .unp_two(unp_two), .unp_pad(unp_pad)
  );

  txlock_param_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .st_we(st_we), .st_idx(st_idx), .st_word(st_word),
    .commit(commit), .commit_owner(sender), .release_i(release_s),
    .locked(locked), .owner(owner), .timeout(timeout),
    .dst_ip(dst_ip), .dst_port(dst_port), .src_port(src_port), .ack_addr(ack_dest)
  );

  txlock_half_unpacker #(.HALF_W(HALF_W)) u_unpack (
    .clk(clk), .rst_n(rst_n),
    .load(unp_load), .word(unp_word), .two_halves(unp_two), .pad_last(unp_pad),
    .hw_rd(hw_rd), .hw_valid(hw_valid), .hw_data(hw_data), .empty(unp_empty)
  );

  // R4
  start_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> locked);
  // R11
  params_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_busy && $past(pkt_busy)) |-> ($stable(dst_ip) && $stable(dst_port)
                                       && $stable(src_port) && $stable(pkt_len)));
  // R11
  payload_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_valid |-> pkt_busy);
endmodule

// File: tb/txlock_decoder_tb_top.sv
module txlock_decoder_tb_top;
  localparam logic [31:0] SND_A = 32'h0000_4C00;
  localparam logic [31:0] SND_B = 32'h0000_7E10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_is_addr = 1'b0;
  logic [31:0] in_data = '0;
  logic        ack_valid;
  logic        ack_ready = 1'b0;
  logic [31:0] ack_data;
  logic [31:0] ack_dest;
  logic        pkt_start;
  logic [10:0] pkt_len;
  logic        pkt_busy;
  logic [31:0] dst_ip;
  logic [15:0] dst_port;
  logic [15:0] src_port;
  logic [27:0] timeout;
  logic        hw_valid;
  logic [15:0] hw_data;
  logic        hw_rd = 1'b0;
  logic        illegal;

  int checks = 0;
  int fails = 0;
  int n_start = 0;
  int n_illegal = 0;
  logic [10:0] seen_len = '0;

  always #10 clk = ~clk;

  txlock_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_addr(in_is_addr), .in_data(in_data), .ack_valid(ack_valid),
    .ack_ready(ack_ready), .ack_data(ack_data), .ack_dest(ack_dest),
    .pkt_start(pkt_start), .pkt_len(pkt_len), .pkt_busy(pkt_busy),
    .dst_ip(dst_ip), .dst_port(dst_port), .src_port(src_port), .timeout(timeout),
    .hw_valid(hw_valid), .hw_data(hw_data), .hw_rd(hw_rd), .illegal(illegal)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (pkt_start) begin
        n_start  = n_start + 1;
        seen_len = pkt_len;
      end
      if (illegal) n_illegal = n_illegal + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic av, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_is_addr = av; in_data = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] start_w(input int len);
    return {4'h1, 11'(len), 17'h0};
  endfunction

  function automatic logic [15:0] hval(input int i);
    return 16'hA0B0 + 16'(i) * 16'h0101;
  endfunction

  task automatic send_cfg(input logic [31:0] snd, input logic [27:0] to, input logic [31:0] ip,
                          input logic [31:0] ports, input logic [31:0] aa);
    push(1'b1, snd);
    push(1'b0, {4'h0, to});
    push(1'b0, ip);
    push(1'b0, ports);
    push(1'b0, aa);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 ack_valid", 32'(ack_valid), 32'd0);
    chk("R1 pkt_busy", 32'(pkt_busy), 32'd0);
    chk("R1 hw_valid", 32'(hw_valid), 32'd0);
  endtask

  task automatic t_unbound_start();
    int i0 = n_illegal;
    push(1'b1, SND_A); push(1'b0, start_w(8)); push(1'b0, 32'h1111_2222);
    settle();
    chk("R5 illegal while unbound", 32'(n_illegal), 32'(i0 + 1));
    chk("R5 no start while unbound", 32'(n_start), 32'd0);
  endtask

  task automatic t_config();
    send_cfg(SND_A, 28'h000_1F40, 32'hC0A8_0A21, 32'h1F90_C350, 32'h0000_0A5C);
    @(negedge clk);
    chk("R2 ack_valid", 32'(ack_valid), 32'd1);
    chk("R2 ack_data", ack_data, 32'h5800_0000);
    chk("R2 ack_dest", ack_dest, 32'h0000_0A5C);
    chk("R2 dst_ip", dst_ip, 32'hC0A8_0A21);
    chk("R2 dst_port", 32'(dst_port), 32'h1F90);
    chk("R2 src_port", 32'(src_port), 32'hC350);
    chk("R2 timeout", 32'(timeout), 32'h0001F40);
    repeat (3) @(negedge clk);
    chk("R3 ack held", 32'(ack_valid), 32'd1);
    chk("R3 ack data held", ack_data, 32'h5800_0000);
    ack_ready = 1'b1;
    @(negedge clk);
    ack_ready = 1'b0;
    chk("R3 ack cleared", 32'(ack_valid), 32'd0);
  endtask

  task automatic t_foreign();
    int i0 = n_illegal;
    int s0 = n_start;
    send_cfg(SND_B, 28'h000_0005, 32'h0A0B_0C0D, 32'h0001_0002, 32'h0000_0333);
    settle();
    chk("R7 illegal", 32'(n_illegal), 32'(i0 + 1));
    chk("R7 dst_ip kept", dst_ip, 32'hC0A8_0A21);
    chk("R7 ports kept", {dst_port, src_port}, 32'h1F90_C350);
    chk("R7 no ack", 32'(ack_valid), 32'd0);
    push(1'b1, SND_B); push(1'b0, start_w(8));
    push(1'b1, SND_B); push(1'b0, 32'h2000_0000);
    settle();
    chk("R5 foreign start and release", 32'(n_illegal), 32'(i0 + 3));
    chk("R5 no start", 32'(n_start), 32'(s0));
  endtask

  task automatic t_zero_len();
    int i0 = n_illegal;
    int s0 = n_start;
    push(1'b1, SND_A); push(1'b0, start_w(0));
    settle();
    chk("R4 zero length no pulse", 32'(n_start), 32'(s0));
    chk("R4 zero length not illegal", 32'(n_illegal), 32'(i0));
  endtask

  task automatic t_other_types();
    int i0 = n_illegal;
    push(1'b1, SND_A); push(1'b0, 32'h3000_0000);
    push(1'b0, 32'h5555_0001); push(1'b0, 32'h5555_0002); push(1'b0, 32'h5555_0003);
    push(1'b1, SND_A); push(1'b0, 32'h9000_0000);
    settle();
    chk("R12 no ack", 32'(ack_valid), 32'd0);
    chk("R12 no illegal", 32'(n_illegal), 32'(i0));
  endtask

  task automatic t_packet(input int len, input int hold);
    int s0 = n_start;
    int nh = (len + 1) / 2;
    int nw = (nh + 1) / 2;
    push(1'b1, SND_A);
    push(1'b0, start_w(len));
    fork
      begin
        for (int k = 0; k < nw; k++) push(1'b0, {hval(2*k+1), hval(2*k)});
      end
      begin
        for (int i = 0; i < nh; i++) begin
          logic [15:0] e;
          e = hval(i);
          if (i == nh - 1 && (len % 2) == 1) e = e & 16'h00FF;
          @(negedge clk);
          while (!hw_valid) @(negedge clk);
          chk((i == nh - 1 && (len % 2) == 1) ? "R9 padded last" : "R8 halfword",
              32'(hw_data), 32'(e));
          chk("R11 in_ready low while held", 32'(in_ready), 32'd0);
          if (i == 0) begin
            chk("R11 busy", 32'(pkt_busy), 32'd1);
            chk("R11 dst_ip", dst_ip, 32'hC0A8_0A21);
          end
          hw_rd = 1'b1;
          if (hold > 1 && i + 1 < nh) begin
            repeat (2) @(negedge clk);
            chk("R10 one take per edge", 32'(hw_data), 32'(hval(i + 1)));
            repeat (hold - 2) @(negedge clk);
          end else begin
            repeat (hold) @(negedge clk);
          end
          hw_rd = 1'b0;
        end
      end
    join
    settle();
    chk("R11 busy cleared", 32'(pkt_busy), 32'd0);
    chk("R4 one pulse", 32'(n_start), 32'(s0 + 1));
    chk("R4 length", 32'(seen_len), 32'(len));
  endtask

  task automatic t_release();
    int i0 = n_illegal;
    int s0 = n_start;
    push(1'b1, SND_A); push(1'b0, 32'h2000_0000);
    settle();
    chk("R6 release not illegal", 32'(n_illegal), 32'(i0));
    push(1'b1, SND_A); push(1'b0, start_w(4));
    settle();
    chk("R6 start after release illegal", 32'(n_illegal), 32'(i0 + 1));
    chk("R6 no start after release", 32'(n_start), 32'(s0));
    send_cfg(SND_B, 28'h000_0077, 32'h0A00_0001, 32'h0050_0051, 32'h0000_0444);
    @(negedge clk);
    chk("R6 other sender binds", 32'(ack_valid), 32'd1);
    chk("R6 new ip", dst_ip, 32'h0A00_0001);
    ack_ready = 1'b1;
    @(negedge clk);
    ack_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unbound_start();
    t_config();
    t_foreign();
    t_zero_len();
    t_other_types();
    t_packet(7, 1);
    t_packet(6, 1);
    t_packet(12, 3);
    t_packet(1, 1);
    t_release();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule